// File: doc/BRIEF.md
# Programmable 3x3 Colour Matrix

This block sits in a pixel pipeline and maps three 8-bit input components to three 8-bit output components. Each output is a signed weighted sum of the three inputs plus a signed offset. The result is rounded to the nearest integer and limited to the 0..255 range. A host loads the weights and offsets byte by byte into a 24-byte coefficient bank. With suitable values the same hardware converts full-range RGB to BT.601 or BT.709 YCbCr, or full-range RGB to limited-range (16..235) RGB.

Host writes go to a shadow copy of the bank. The shadow copy moves into the working copy only on a frame-start pulse, so a frame never mixes two coefficient sets. A per-pixel enable picks either the matrix result or the raw input. A per-pixel swap control exchanges components 0 and 2 at the output. The valid, data-enable and sync qualifiers travel alongside the pixel with the same latency as the data.

Top module: `color_matrix3`

## Requirements
- R1: The values of `in_valid`, `in_de` and `in_sync` sampled at clock edge k appear on `out_valid`, `out_de` and `out_sync` after edge k+2, which is three register stages. Pixel data and the `mat_en` and `comp_swap` controls use the same alignment.
- R2: While `rst` is high, every output is driven to 0. Reset loads both bank copies with the unity matrix: coefficient 0x0400 on the diagonal, 0 elsewhere, and zero offsets. After reset, an enabled pixel therefore passes through unchanged.
- R3: Bank byte 8r+2j holds the high byte and byte 8r+2j+1 the low byte of 16-bit word j of output row r (r = 0..2). Words j = 0, 1, 2 multiply input components 0, 1, 2, and word j = 3 is the row offset. The matrix result is out_r = floor((sum of coef_rj * in_j + offset_r * 1024 + 512) / 1024).
- R4: In a multiplier word, bits 11:0 are an unsigned magnitude with 10 fractional bits, so 0x0400 means 1.0. Bit 12 set makes the coefficient negative. Bits 15:13 are ignored.
- R5: Rounding adds half an LSB (512) before the 10-bit arithmetic shift, so a fractional part of exactly one half rounds up.
- R6: The matrix result is clamped: values below 0 give 0 and values above 255 give 255.
- R7: The offset word is a sign-magnitude integer: bits 11:0 are the magnitude and bit 12 is the sign. It is added in whole output units, for example 16 for luma or limited RGB and 128 for chroma.
- R8: When `mat_en` is 0 for a pixel, that pixel's components leave unchanged after the R1 latency.
- R9: When `comp_swap` is 1 for a pixel, output components 0 and 2 are exchanged after the matrix-or-bypass selection. This applies in both modes.
- R10: A host write changes only the shadow bank. Pixels sampled at the same edge as a `frame_start` pulse, or before it, use the previous working bank. The shadow bank is copied into the working bank at the `frame_start` edge.
- R11: Host writes with `cfg_addr` of 24 or more have no effect on either bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Host byte write strobe |
| cfg_addr | input | 5 | Byte index into the coefficient bank |
| cfg_wdata | input | 8 | Byte to write |
| frame_start | input | 1 | Frame boundary pulse; commits the shadow bank |
| mat_en | input | 1 | 1 = matrix result, 0 = bypass (per pixel) |
| comp_swap | input | 1 | Exchange output components 0 and 2 (per pixel) |
| in_valid | input | 1 | Input pixel valid |
| in_de | input | 1 | Input data enable |
| in_sync | input | 1 | Input sync marker |
| in_c0 | input | 8 | Input component 0 |
| in_c1 | input | 8 | Input component 1 |
| in_c2 | input | 8 | Input component 2 |
| out_valid | output | 1 | Delayed valid |
| out_de | output | 1 | Delayed data enable |
| out_sync | output | 1 | Delayed sync |
| out_c0 | output | 8 | Output component 0 |
| out_c1 | output | 8 | Output component 1 |
| out_c2 | output | 8 | Output component 2 |

## Verification
The bench loads banks with negative weights and chroma offsets. A design that ignored the sign bit, or read the words in the wrong byte order, would give visibly wrong YCbCr values.

Weights of 2.0 and -1.0 drive results past both ends of the output range, which exposes a design that wraps instead of clamping. A weight of 0.5 applied to odd inputs lands exactly on half-LSB results, which catches truncation or round-to-even.

Bank writes made without a frame pulse, writes to addresses past the bank, and a write in the same cycle as the frame pulse would each change pixels too early in a design without correct double buffering. A swap applied at the wrong stage, or a qualifier pipe one stage short, would show up as misaligned components or misaligned valid/DE.

// File: rtl/csc_pkg.sv
package csc_pkg;
    localparam int PIX_W      = 8;
    localparam int NCOMP      = 3;
    localparam int WORD_W     = 16;
    localparam int MAG_W      = 12;
    localparam int SIGN_POS   = 12;
    localparam int FRAC_W     = 10;
    localparam int WPR        = NCOMP + 1;
    localparam int BANK_BYTES = NCOMP * WPR * 2;
    localparam int ADDR_W     = $clog2(BANK_BYTES);
    localparam int PROD_W     = MAG_W + PIX_W + 1;
    localparam int ACC_W      = PROD_W + 4;
    localparam int SH_W       = ACC_W - FRAC_W;
    localparam int LAT        = 3;

    typedef logic [PIX_W-1:0]              pix_t;
    typedef pix_t [NCOMP-1:0]              trio_t;
    typedef logic [BANK_BYTES-1:0][7:0]    bank_t;
    typedef logic [WORD_W-1:0]             cword_t;

    typedef struct packed {
        cword_t [NCOMP-1:0] mul;
        cword_t             ofs;
    } row_cfg_t;

    typedef struct packed {
        logic  valid;
        logic  de;
        logic  sync;
        logic  en;
        logic  swap;
        trio_t raw;
    } side_t;

    function automatic cword_t bank_word(bank_t b, int idx);
        return {b[2*idx], b[2*idx+1]};
    endfunction

    function automatic row_cfg_t row_of(bank_t b, int r);
        row_cfg_t c;
        for (int k = 0; k < NCOMP; k++) c.mul[k] = bank_word(b, r*WPR + k);
        c.ofs = bank_word(b, r*WPR + NCOMP);
        return c;
    endfunction

    function automatic bank_t unity_bank();
        bank_t  b;
        cword_t one;
        b   = '0;
        one = cword_t'(1 << FRAC_W);
        for (int r = 0; r < NCOMP; r++) begin
            b[2*(r*WPR + r)]     = one[15:8];
            b[2*(r*WPR + r) + 1] = one[7:0];
        end
        return b;
    endfunction

    function automatic logic signed [PROD_W-1:0] signed_term(cword_t w, pix_t p);
        logic [PROD_W-2:0] m;
        m = w[MAG_W-1:0] * p;
        return w[SIGN_POS] ? -$signed({1'b0, m}) : $signed({1'b0, m});
    endfunction

    function automatic logic signed [ACC_W-1:0] offset_term(cword_t w);
        logic [ACC_W-1:0] m;
        m = ACC_W'(w[MAG_W-1:0]) << FRAC_W;
        return w[SIGN_POS] ? -$signed(m) : $signed(m);
    endfunction

    function automatic pix_t clamp_pix(logic signed [SH_W-1:0] v);
        if (v[SH_W-1])
            return '0;
        else if (v > $signed({{(SH_W-PIX_W){1'b0}}, {PIX_W{1'b1}}}))
            return '1;
        else
            return v[PIX_W-1:0];
    endfunction
endpackage

// File: rtl/csc_coef_bank.sv
module csc_coef_bank
    import csc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              frame_start,
    output bank_t             active_o
);
    localparam bank_t UNITY = unity_bank();

    bank_t shadow_q;
    bank_t active_q;

    for (genvar i = 0; i < BANK_BYTES; i++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst) begin
                shadow_q[i] <= UNITY[i];
                active_q[i] <= UNITY[i];
            end else begin
                if (frame_start)
                    active_q[i] <= shadow_q[i];
                if (wr_en && (wr_addr == ADDR_W'(i)))
                    shadow_q[i] <= wr_data;
            end
        end
    end

    assign active_o = active_q;

    // R10: working bank only moves at a frame boundary
    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> $stable(active_q));
    // R10: the commit takes the shadow contents of the commit edge
    assert_commit_R10: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> (active_q == $past(shadow_q)));
    // R11: out-of-bank writes leave the shadow untouched
    assert_ignore_R11: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_addr >= ADDR_W'(BANK_BYTES))) |=> $stable(shadow_q));
endmodule

// File: rtl/csc_row.sv
module csc_row
    import csc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  row_cfg_t cfg_i,
    input  trio_t    pix_i,
    output pix_t     res_o
);
    logic signed [PROD_W-1:0] prod_q [NCOMP];
    logic signed [ACC_W-1:0]  ofs_q;
    logic signed [ACC_W-1:0]  acc_q;
    logic signed [ACC_W-1:0]  sum_c;
    logic signed [SH_W-1:0]   sh_c;
    pix_t                     res_q;

    // stage 1: signed products and offset with rounding half
    for (genvar k = 0; k < NCOMP; k++) begin : g_prod
        always_ff @(posedge clk) begin
            if (rst) prod_q[k] <= '0;
            else     prod_q[k] <= signed_term(cfg_i.mul[k], pix_i[k]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ofs_q <= '0;
        else     ofs_q <= offset_term(cfg_i.ofs) + $signed(ACC_W'(1 << (FRAC_W-1)));
    end

    // stage 2: accumulate
    always_comb begin
        sum_c = ofs_q;
        for (int k = 0; k < NCOMP; k++)
            sum_c = sum_c + ACC_W'(prod_q[k]);
    end

    always_ff @(posedge clk) begin
        if (rst) acc_q <= '0;
        else     acc_q <= sum_c;
    end

    // stage 3: scale down and clamp
    assign sh_c = SH_W'(acc_q >>> FRAC_W);

    always_ff @(posedge clk) begin
        if (rst) res_q <= '0;
        else     res_q <= clamp_pix(sh_c);
    end

    assign res_o = res_q;
endmodule

// File: rtl/color_matrix3.sv
module color_matrix3
    import csc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_we,
    input  logic [4:0] cfg_addr,
    input  logic [7:0] cfg_wdata,
    input  logic       frame_start,
    input  logic       mat_en,
    input  logic       comp_swap,
    input  logic       in_valid,
    input  logic       in_de,
    input  logic       in_sync,
    input  logic [7:0] in_c0,
    input  logic [7:0] in_c1,
    input  logic [7:0] in_c2,
    output logic       out_valid,
    output logic       out_de,
    output logic       out_sync,
    output logic [7:0] out_c0,
    output logic [7:0] out_c1,
    output logic [7:0] out_c2
);
    localparam int CNT_W = $clog2(LAT + 1);

    bank_t    active_bank;
    trio_t    in_trio;
    trio_t    row_res;
    trio_t    sel_c;
    trio_t    fin_c;
    row_cfg_t rcfg [NCOMP];
    side_t    side_in;
    side_t    pipe_q [LAT];
    side_t    tail;

    assign in_trio = {in_c2, in_c1, in_c0};

    csc_coef_bank u_bank (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (cfg_we),
        .wr_addr     (cfg_addr),
        .wr_data     (cfg_wdata),
        .frame_start (frame_start),
        .active_o    (active_bank)
    );

    for (genvar r = 0; r < NCOMP; r++) begin : g_row
        assign rcfg[r] = row_of(active_bank, r);
        csc_row u_row (
            .clk   (clk),
            .rst   (rst),
            .cfg_i (rcfg[r]),
            .pix_i (in_trio),
            .res_o (row_res[r])
        );
    end

    always_comb begin
        side_in       = '0;
        side_in.valid = in_valid;
        side_in.de    = in_de;
        side_in.sync  = in_sync;
        side_in.en    = mat_en;
        side_in.swap  = comp_swap;
        side_in.raw   = in_trio;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LAT; i++) pipe_q[i] <= '0;
        end else begin
            pipe_q[0] <= side_in;
            for (int i = 1; i < LAT; i++) pipe_q[i] <= pipe_q[i-1];
        end
    end

    assign tail  = pipe_q[LAT-1];
    assign sel_c = tail.en ? row_res : tail.raw;

    always_comb begin
        fin_c = sel_c;
        if (tail.swap) begin
            fin_c[0] = sel_c[NCOMP-1];
            fin_c[NCOMP-1] = sel_c[0];
        end
    end

    assign out_valid = tail.valid;
    assign out_de    = tail.de;
    assign out_sync  = tail.sync;
    assign out_c0    = fin_c[0];
    assign out_c1    = fin_c[1];
    assign out_c2    = fin_c[2];

    // cycles since reset, saturating at the pipeline depth
    logic [CNT_W-1:0] settle_q;
    always_ff @(posedge clk) begin
        if (rst)                         settle_q <= '0;
        else if (settle_q != CNT_W'(LAT)) settle_q <= settle_q + 1'b1;
    end

    // R1: qualifiers delayed by exactly the pipeline depth
    assert_latency_R1: assert property (@(posedge clk) disable iff (rst)
        (settle_q == CNT_W'(LAT)) |->
        ({out_valid, out_de, out_sync} == $past({in_valid, in_de, in_sync}, LAT)));
    // R8: bypassed, unswapped pixels leave untouched
    assert_bypass_R8: assert property (@(posedge clk) disable iff (rst)
        ((settle_q == CNT_W'(LAT)) && !$past(mat_en, LAT) && !$past(comp_swap, LAT)) |->
        ({out_c2, out_c1, out_c0} == $past({in_c2, in_c1, in_c0}, LAT)));
endmodule

// File: tb/color_matrix3_tb_top.sv
`timescale 1ns/1ps
module color_matrix3_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [4:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic       frame_start = 1'b0;
    logic       mat_en = 1'b0;
    logic       comp_swap = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_de = 1'b0;
    logic       in_sync = 1'b0;
    logic [7:0] in_c0 = '0;
    logic [7:0] in_c1 = '0;
    logic [7:0] in_c2 = '0;
    logic       out_valid, out_de, out_sync;
    logic [7:0] out_c0, out_c1, out_c2;

    always #2.5 clk = ~clk;

    color_matrix3 dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .frame_start(frame_start), .mat_en(mat_en),
        .comp_swap(comp_swap), .in_valid(in_valid), .in_de(in_de),
        .in_sync(in_sync), .in_c0(in_c0), .in_c1(in_c1), .in_c2(in_c2),
        .out_valid(out_valid), .out_de(out_de), .out_sync(out_sync),
        .out_c0(out_c0), .out_c1(out_c1), .out_c2(out_c2)
    );

    int    vectors = 0;
    int    fails   = 0;
    bit    done    = 0;
    string cur_tag = "R2";

    // behavioural reference: byte banks, queue of expected outputs
    int           m_sh  [24];
    int           m_act [24];
    logic [26:0]  q_exp [$];
    string        q_tag [$];

    function automatic void set_unity();
        for (int i = 0; i < 24; i++) begin m_sh[i] = 0; m_act[i] = 0; end
        for (int r = 0; r < 3; r++) begin
            m_sh[8*r + 2*r]  = 4;
            m_act[8*r + 2*r] = 4;
        end
    endfunction

    function automatic int sm_val(int hi, int lo);
        int w;
        w = hi * 256 + lo;
        return ((w / 4096) % 2 == 1) ? -(w % 4096) : (w % 4096);
    endfunction

    function automatic int row_val(int r, int a0, int a1, int a2);
        int acc;
        acc = sm_val(m_act[8*r+0], m_act[8*r+1]) * a0
            + sm_val(m_act[8*r+2], m_act[8*r+3]) * a1
            + sm_val(m_act[8*r+4], m_act[8*r+5]) * a2
            + sm_val(m_act[8*r+6], m_act[8*r+7]) * 1024 + 512;
        acc = acc >>> 10;
        if (acc < 0)   acc = 0;
        if (acc > 255) acc = 255;
        return acc;
    endfunction

    always @(posedge clk) begin
        int v0, v1, v2, t;
        if (rst) begin
            set_unity();
            q_exp.push_back('0);
            q_tag.push_back(cur_tag);
        end else begin
            if (mat_en) begin
                v0 = row_val(0, in_c0, in_c1, in_c2);
                v1 = row_val(1, in_c0, in_c1, in_c2);
                v2 = row_val(2, in_c0, in_c1, in_c2);
            end else begin
                v0 = in_c0; v1 = in_c1; v2 = in_c2;
            end
            if (comp_swap) begin t = v0; v0 = v2; v2 = t; end
            q_exp.push_back({in_valid, in_de, in_sync, 8'(v2), 8'(v1), 8'(v0)});
            q_tag.push_back(cur_tag);
            if (frame_start) m_act = m_sh;
            if (cfg_we && cfg_addr < 24) m_sh[cfg_addr] = cfg_wdata;
        end
    end

    always @(negedge clk) begin
        logic [26:0] e, g;
        string tg;
        if (!done && q_exp.size() == 3) begin
            e  = q_exp.pop_front();
            tg = q_tag.pop_front();
            g  = {out_valid, out_de, out_sync, out_c2, out_c1, out_c0};
            vectors++;
            if (g[26:24] != e[26:24]) begin
                fails++;
                $display("FAIL R1 qualifiers: actual %b expected %b", g[26:24], e[26:24]);
            end else if (g[23:0] != e[23:0]) begin
                fails++;
                $display("FAIL %s data: actual %h expected %h", tg, g[23:0], e[23:0]);
            end
        end
    end

    task automatic wr_byte(input int a, input int d);
        cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = 8'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic load_row(input int r, input int w0, input int w1, input int w2, input int ofs);
        int w[4];
        w = '{w0, w1, w2, ofs};
        for (int j = 0; j < 4; j++) begin
            wr_byte(8*r + 2*j,     (w[j] >> 8) & 255);
            wr_byte(8*r + 2*j + 1, w[j] & 255);
        end
    endtask

    task automatic commit();
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic pix(input int a0, input int a1, input int a2, input bit sy);
        in_valid = 1'b1; in_de = 1'b1; in_sync = sy;
        in_c0 = 8'(a0); in_c1 = 8'(a1); in_c2 = 8'(a2);
        @(negedge clk);
        in_valid = 1'b0; in_de = 1'b0; in_sync = 1'b0;
    endtask

    task automatic rand_pix(input int n);
        for (int i = 0; i < n; i++)
            pix($urandom_range(0, 255), $urandom_range(0, 255), $urandom_range(0, 255), (i % 5) == 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL R1 watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        // R2: reset state, then unity bank passes data through
        repeat (4) @(negedge clk);
        rst = 1'b0;
        mat_en = 1'b1;
        pix(0, 128, 255, 1);
        rand_pix(6);
        // R1: sideband patterns with gaps
        cur_tag = "R1";
        in_sync = 1'b1; @(negedge clk); in_sync = 1'b0;
        in_de = 1'b1;   @(negedge clk); in_de = 1'b0;
        rand_pix(3);
        // R10: shadow writes without commit must not change output
        cur_tag = "R10";
        for (int r = 0; r < 3; r++)
            load_row(r, (r == 0) ? 16'h036F : 0, (r == 1) ? 16'h036F : 0, (r == 2) ? 16'h036F : 0, 16);
        rand_pix(4);
        // R7: limited-range scaling with offset 16 after commit
        cur_tag = "R7";
        commit();
        pix(0, 0, 0, 0);
        pix(255, 255, 255, 0);
        rand_pix(6);
        // R3 R4: signed weights, chroma offset 128
        cur_tag = "R4";
        load_row(0, 16'h0107, 16'h0204, 16'h0064, 16);
        load_row(1, 16'h1098, 16'h112A, 16'h01C2, 128);
        load_row(2, 16'h01C2, 16'h1179, 16'h1049, 16'h0080);
        commit();
        cur_tag = "R3";
        pix(255, 0, 0, 0); pix(0, 255, 0, 0); pix(0, 0, 255, 0);
        rand_pix(10);
        // R4: bits 15:13 ignored, negative offset
        cur_tag = "R4";
        load_row(0, 16'hE400, 0, 0, 16'h1005);
        commit();
        pix(3, 9, 9, 0); pix(200, 1, 1, 0);
        // R6: clamp high and low
        cur_tag = "R6";
        load_row(0, 16'h0800, 0, 0, 0);
        load_row(1, 0, 16'h1400, 0, 0);
        load_row(2, 0, 0, 16'h0400, 16'h0FFF);
        commit();
        pix(200, 50, 0, 0); pix(127, 0, 1, 0); pix(128, 255, 255, 0);
        // R5: half-LSB results round up
        cur_tag = "R5";
        load_row(0, 16'h0200, 0, 0, 0);
        load_row(1, 0, 16'h0200, 0, 0);
        load_row(2, 0, 0, 16'h0100, 0);
        commit();
        pix(1, 3, 2, 0); pix(5, 255, 6, 0); pix(0, 254, 1, 0);
        // R8: bypass
        cur_tag = "R8";
        mat_en = 1'b0;
        pix(1, 2, 3, 0);
        rand_pix(4);
        // R9: swap in bypass and matrix modes
        cur_tag = "R9";
        comp_swap = 1'b1;
        pix(10, 20, 30, 0);
        mat_en = 1'b1;
        pix(10, 20, 30, 0);
        rand_pix(3);
        comp_swap = 1'b0;
        // R11: writes past the bank are dropped
        cur_tag = "R11";
        for (int a = 24; a < 32; a++) wr_byte(a, 8'hFF);
        commit();
        pix(9, 7, 5, 0);
        rand_pix(3);
        // R10: write coinciding with commit lands only in the shadow
        cur_tag = "R10";
        cfg_we = 1'b1; cfg_addr = 5'd1; cfg_wdata = 8'h80; frame_start = 1'b1;
        in_valid = 1'b1; in_c0 = 8'd40;
        @(negedge clk);
        cfg_we = 1'b0; frame_start = 1'b0; in_valid = 1'b0;
        pix(40, 0, 0, 0);
        commit();
        pix(40, 0, 0, 0);
        repeat (6) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule